// File: doc/BRIEF.md
# Anode Dimming Pulse Generator

This block produces the segment-enable pulse that sets how bright a multiplexed fluorescent display appears. Each grid slot is divided into 1024 bit times, and the pulse stays high for as many bit times as the programmed 10-bit brightness value. The same width is used in every grid slot. One bit time is marked by a single-cycle enable, which the surrounding timing logic raises once every four oscillator clocks. A separate strobe marks the start of each slot.

When the block is the master, its own counter shapes the pulse. That pulse gates every segment output and is also driven out so that slave chips can follow it. When the block is a slave, it ignores its own counter. The segment enable then follows an external dimming input, and the dimming output is held low.

The largest width is 1016/1024 of a slot, so the end of every slot is always blanked. Any larger value saturates at that limit. A new brightness value is sampled only at a slot start, so a slot never shows a partial or mixed pulse.

Top module: `anode_dimmer`

## Requirements
- R1: After reset, the held brightness is 0. Until the first slot-start strobe, `seg_en` and `dim_out` stay low in master mode, whatever value `dim_level` presents.
- R2: In master mode, for a value V of at most 1016 sampled at a slot start, `seg_en` is high for exactly V bit times of that slot.
- R3: A sampled value above 1016 gives exactly 1016 high bit times. For example, 1017 and 1023 both give 1016, while 1015 gives 1015.
- R4: Within a master slot, the pulse is one contiguous high run that starts in the first cycle after the strobe edge (when V > 0). The pulse then falls once and stays low until the next strobe.
- R5: A change on `dim_level` during a slot has no effect on that slot. It is used from the next slot start.
- R6: In slave mode (`master_sel` = 0), `seg_en` equals `ext_dim_in` in every cycle (1 = segments driven, 0 = off), and `dim_out` is 0.
- R7: In master mode, `ext_dim_in` has no effect, and `dim_out` equals `seg_en` in every cycle.
- R8: If no strobe arrives after the count has passed the pulse, the counter stops at its top value. It does not wrap, and the pulse stays low.
- R9: The count advances only in cycles where `bit_tick` is high. With one tick every N clocks, the pulse lasts V·N clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle bit-time enable |
| slot_start | input | 1 | Grid-slot start strobe; restarts the count and samples `dim_level` |
| dim_level | input | 10 | Programmed brightness, in 1024ths of a slot |
| master_sel | input | 1 | 1 = master (internal pulse), 0 = slave |
| ext_dim_in | input | 1 | Dimming pulse from an external master |
| seg_en | output | 1 | Segment enable |
| dim_out | output | 1 | Dimming pulse for slave chips |

## Verification
Some properties are checked on every cycle:
- In slave mode, `seg_en` follows the external input and `dim_out` stays low.
- In master mode, `dim_out` mirrors the pulse.
- The held value changes only after a strobe.
- No slot collects more than 1016 high bit times.
- Once the master pulse has fallen, it stays low until the next strobe.

Other behaviour is shown only by the bench scenarios:
- The exact width for each value, including saturation at the cap.
- The scaling of the width with the tick spacing.
- That a mid-slot write to `dim_level` is deferred to the next slot.
- That the dark state after reset persists.

// File: rtl/anode_dimmer.sv
module anode_dimmer #(
  parameter int DIM_W = 10,
  parameter int BLANK = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             slot_start,
  input  logic [DIM_W-1:0] dim_level,
  input  logic             master_sel,
  input  logic             ext_dim_in,
  output logic             seg_en,
  output logic             dim_out
);
  localparam int CAP_I = (1 << DIM_W) - BLANK;
  localparam logic [DIM_W-1:0] CAP = CAP_I[DIM_W-1:0];
  localparam logic [DIM_W-1:0] TOP = {DIM_W{1'b1}};

  logic [DIM_W-1:0] cnt_q, act_q;
  logic pulse;

  wire [DIM_W-1:0] clamped = (dim_level > CAP) ? CAP : dim_level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else if (slot_start) begin
      cnt_q <= '0;
      act_q <= clamped;
    end else if (bit_tick && cnt_q != TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pulse   = cnt_q < act_q;
  assign seg_en  = master_sel ? pulse : ext_dim_in;
  assign dim_out = master_sel & pulse;
endmodule

module anode_dimmer_chk #(
  parameter int DIM_W = 10,
  parameter int CAP_I = 1016
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic             slot_start,
  input logic             master_sel,
  input logic             ext_dim_in,
  input logic             seg_en,
  input logic             dim_out,
  input logic [DIM_W-1:0] act_q
);
  logic [DIM_W:0] hi_cnt;
  logic prev_seg, prev_master, fallen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt      <= '0;
      prev_seg    <= 1'b0;
      prev_master <= 1'b0;
      fallen      <= 1'b0;
    end else begin
      prev_seg    <= seg_en;
      prev_master <= master_sel;
      if (slot_start) begin
        hi_cnt <= '0;
        fallen <= 1'b0;
      end else begin
        if (master_sel && seg_en && bit_tick) hi_cnt <= hi_cnt + 1'b1;
        if (master_sel && prev_master && prev_seg && !seg_en) fallen <= 1'b1;
      end
    end
  end

  assert_slave_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !master_sel |-> (seg_en == ext_dim_in) && !dim_out);

  assert_mirror_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    master_sel |-> dim_out == seg_en);

  assert_hold_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(slot_start) |-> $stable(act_q));

  assert_width_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cnt <= (DIM_W+1)'(CAP_I));

  assert_single_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fallen && master_sel && prev_master) |-> !seg_en);
endmodule

bind anode_dimmer anode_dimmer_chk #(.DIM_W(DIM_W), .CAP_I(CAP_I)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .slot_start(slot_start),
  .master_sel(master_sel), .ext_dim_in(ext_dim_in), .seg_en(seg_en),
  .dim_out(dim_out), .act_q(act_q)
);

// File: tb/sim_anode_dimmer.sv
module sim_anode_dimmer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic slot_start = 1'b0;
  logic [9:0] dim_level = '0;
  logic master_sel = 1'b1;
  logic ext_dim_in = 1'b0;
  logic seg_en, dim_out;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  anode_dimmer u0 (.clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .slot_start(slot_start),
    .dim_level(dim_level), .master_sel(master_sel), .ext_dim_in(ext_dim_in),
    .seg_en(seg_en), .dim_out(dim_out));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_slot(input int level, input int div, input int new_level_at,
                          input int new_level, input string req);
    int highs = 0, rises = 0, falls = 0, mism = 0, first = 0, exp;
    logic prev;
    exp = ((level > 1016) ? 1016 : level) * div;
    dim_level  = 10'(level);
    slot_start = 1'b1;
    bit_tick   = 1'b0;
    @(posedge clk); @(negedge clk);
    slot_start = 1'b0;
    prev = seg_en;
    first = seg_en;
    for (int i = 0; i < 1024 * div; i++) begin
      if (seg_en) highs++;
      if (seg_en && !prev) rises++;
      if (!seg_en && prev) falls++;
      if (dim_out != seg_en) mism++;
      prev = seg_en;
      if (i == new_level_at) dim_level = 10'(new_level);
      ext_dim_in = i[0];
      bit_tick = ((i % div) == div - 1);
      @(posedge clk); @(negedge clk);
    end
    bit_tick = 1'b0;
    check({req, " width"}, highs, exp);
    check("R4 starts high", first, exp > 0 ? 1 : 0);
    check("R4 single run", rises * 10 + falls, exp > 0 ? 1 : 0);
    check("R7 dim_out mirrors / ext ignored", mism, 0);
  endtask

  initial begin
    int highs;
    int mism;
    int vals[15] = '{0, 1, 2, 7, 8, 255, 256, 511, 512, 1000, 1015, 1016, 1017, 1020, 1023};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    dim_level = 10'd500;
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      bit_tick = 1'b1;
      ext_dim_in = 1'b1;
      if (seg_en || dim_out) highs++;
      @(posedge clk); @(negedge clk);
    end
    check("R1 dark after reset", highs, 0);

    foreach (vals[k])
      run_slot(vals[k], 1, -1, 0, (vals[k] > 1016) ? "R3 clamp" : "R2 duty");

    run_slot(3, 4, -1, 0, "R9 tick spacing");
    run_slot(1016, 4, -1, 0, "R9 tick spacing cap");
    run_slot(600, 3, -1, 0, "R9 tick spacing");

    run_slot(100, 1, 50, 900, "R5 mid-slot write ignored");
    run_slot(900, 1, -1, 0, "R5 next slot uses new value");

    highs = 0;
    for (int i = 0; i < 2000; i++) begin
      bit_tick = 1'b1;
      if (seg_en) highs++;
      @(posedge clk); @(negedge clk);
    end
    check("R8 no wrap without strobe", highs, 0);

    master_sel = 1'b0;
    mism = 0;
    for (int i = 0; i < 300; i++) begin
      ext_dim_in = ((i * 7) % 5) < 2;
      bit_tick = i[0];
      slot_start = (i % 97) == 0;
      dim_level = 10'(i * 3);
      #1;
      if (seg_en != ext_dim_in || dim_out != 1'b0) mism++;
      @(posedge clk); @(negedge clk);
    end
    slot_start = 1'b0;
    check("R6 slave follows ext input", mism, 0);
    master_sel = 1'b1;

    run_slot(1023, 1, -1, 0, "R3 clamp after slave");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule